// File: doc/BRIEF.md
# Synchronous Burst SRAM Model with Byte Lanes and Nap Sequencing

This block is a synthesizable behavioural model of a single-ported synchronous burst SRAM. Every rising clock edge it samples three chip selects, two address strobes, an advance input, the write enables and an address. From these it decides whether to start a burst, continue one, hold it in place or drop out of selection. Writes are masked per byte lane. Reads are registered, so data for an address captured at an edge is presented right after that edge.

The data bus is split into an input half, an output half and a drive-enable. The drive-enable is gated without a clock by the output-enable pin, by any write request on the pins and by the nap input.

The burst counter is two bits wide. It walks the low address bits in either linear or interleaved (XOR) order, chosen by a mode pin. A nap input parks the block in a low-power state after two clock edges and leaves it after two more. During the next two edges the address strobes must stay idle. A strobe seen in that recovery window is ignored, and it sets a sticky protocol-error flag.

Top module: `sbsram`

## Requirements
- R1: With `wr_all_n` high and `lane_wr_n` low, a write updates only the byte lanes whose `lane_sel_n[i]` is low (lane i occupies data bits i*LW to i*LW+LW-1). The other lanes of that word keep their contents.
- R2: The write qualifier is active when `wr_all_n` is low, which writes all lanes. It is also active when `lane_wr_n` is low and at least one `lane_sel_n` bit is low. Otherwise the cycle is a read, even if some `lane_sel_n` bits are low.
- R3: `proc_strb_n` low at an edge with `cs0_n` low and the chip selected (`cs1` high, `cs2_n` low) starts a read at `addr`, whatever the write enables are. Later edges of that burst write when the qualifier is active.
- R4: An edge with `cs0_n` high and `ctl_strb_n` low ends any burst and leaves the bus undriven. So does an edge with `cs0_n` low, the chip not fully selected, and either strobe low. A following `step_n` low then accesses nothing.
- R5: With no strobe active and a burst open, `step_n` low advances the two-bit count. The low address bits become (start+n) mod 4 when `lin_order` is 1, and start XOR n when it is 0. The upper address bits stay fixed.
- R6: The word read at an edge appears on `bus_o`, with `bus_oe` high, from that edge until the next one, provided that nothing else masks the drivers.
- R7: `bus_oe` is low whenever `drv_en_n` is high. The pin acts combinationally, with no clock.
- R8: `bus_oe` is low whenever the write qualifier is active on the pins, and after any edge that performed a write.
- R9: `nap` high for two edges puts the block to sleep. While asleep, or whenever `nap` is high, `bus_oe` is low. While asleep, strobes are ignored and an open burst is abandoned, but array contents are preserved.
- R10: During the two edges after sleep ends, strobes start nothing. A low strobe in that window sets `proto_err`, which stays high until reset.
- R11: After reset, `proto_err` and `bus_oe` are low and no burst is open.
- R12: With a burst open, an edge with no strobe and `step_n` high repeats the access at the current burst address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cs0_n | input | 1 | Primary chip select, active low; gates the processor strobe |
| cs1 | input | 1 | Second chip select, active high |
| cs2_n | input | 1 | Third chip select, active low |
| proc_strb_n | input | 1 | Processor address strobe, always starts a read |
| ctl_strb_n | input | 1 | Controller address strobe, starts a read or a write |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write every lane, active low |
| lane_wr_n | input | 1 | Enable for per-lane writes, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | AW | Word address |
| bus_i | input | LANES*LW | Write data from the shared bus |
| bus_o | output | LANES*LW | Registered read data |
| bus_oe | output | 1 | Bus drive enable |
| drv_en_n | input | 1 | Output enable, asynchronous, active low |
| nap | input | 1 | Sleep request |
| proto_err | output | 1 | Sticky flag for a strobe seen during nap recovery |

## Verification
The bench builds the block with AW=6, which gives a 64-word array, and keeps four 9-bit lanes. With that depth a short preload writes every word, so every later read has a known value. The burst tests then reach both wrap orders from every start offset within a few cycles. The four lanes allow the mixed masks needed to check lane isolation.

The reference model applies the selection, strobe priority, nap and recovery rules every clock. It also compares the drive-enable just after each input change, which exposes the combinational masking by output enable, write request and nap.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        logic       open;
        logic [1:0] first;
        logic [1:0] count;
    } burst_t;

    localparam int unsigned REC_EDGES = 2;

    function automatic logic [1:0] burst_low(input logic [1:0] first,
                                             input logic [1:0] count,
                                             input logic       linear);
        return linear ? (first + count) : (first ^ count);
    endfunction

endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
    import sbsram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs0_n,
    input  logic          cs1,
    input  logic          cs2_n,
    input  logic          proc_strb_n,
    input  logic          ctl_strb_n,
    input  logic          step_n,
    input  logic          wq,
    input  logic          lin_order,
    input  logic [AW-1:0] addr,
    input  logic          nap,
    output op_e           op,
    output logic [AW-1:0] acc_addr,
    output logic          asleep,
    output logic          proto_err
);
    localparam int RW = $clog2(REC_EDGES + 1);

    burst_t          bst_q, bst_d;
    logic [AW-3:0]   base_q, base_d;
    logic            nap_s1;
    logic [RW-1:0]   rec_q;
    logic            err_set;
    logic            sel;

    assign sel = !cs0_n && cs1 && !cs2_n;

    always_comb begin
        op       = OP_NONE;
        bst_d    = bst_q;
        base_d   = base_q;
        err_set  = 1'b0;
        acc_addr = {base_q, burst_low(bst_q.first, bst_q.count, lin_order)};
        if (asleep) begin
            bst_d.open = 1'b0;
        end else if (rec_q != '0) begin
            err_set = !proc_strb_n || !ctl_strb_n;
        end else if ((!proc_strb_n && !cs0_n) || !ctl_strb_n) begin
            if (sel) begin
                bst_d.open  = 1'b1;
                bst_d.first = addr[1:0];
                bst_d.count = 2'd0;
                base_d      = addr[AW-1:2];
                acc_addr    = addr;
                op          = (!proc_strb_n && !cs0_n) ? OP_READ
                            : (wq ? OP_WRITE : OP_READ);
            end else begin
                bst_d.open = 1'b0;
            end
        end else if (bst_q.open) begin
            if (!step_n) begin
                bst_d.count = bst_q.count + 2'd1;
            end
            acc_addr = {base_q, burst_low(bst_q.first, bst_d.count, lin_order)};
            op       = wq ? OP_WRITE : OP_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bst_q     <= '0;
            base_q    <= '0;
            nap_s1    <= 1'b0;
            asleep    <= 1'b0;
            rec_q     <= '0;
            proto_err <= 1'b0;
        end else begin
            bst_q  <= bst_d;
            base_q <= base_d;
            nap_s1 <= nap;
            asleep <= nap_s1;
            if (asleep) begin
                rec_q <= RW'(REC_EDGES);
            end else if (rec_q != '0) begin
                rec_q <= rec_q - 1'b1;
            end
            if (err_set) begin
                proto_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
    import sbsram_pkg::*;
#(
    parameter int AW    = 10,
    parameter int LANES = 4,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  op_e                 op,
    input  logic [AW-1:0]       acc_addr,
    input  logic [LANES-1:0]    lane_we,
    input  logic [LANES*LW-1:0] wdata,
    output logic [LANES*LW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (op == OP_WRITE && lane_we[g]) begin
                mem[acc_addr] <= wdata[g*LW +: LW];
            end
            if (op == OP_READ) begin
                rdata[g*LW +: LW] <= mem[acc_addr];
            end
        end
    end

endmodule

// File: rtl/sbsram_busctl.sv
module sbsram_busctl
    import sbsram_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_e  op,
    input  logic drv_en_n,
    input  logic wq,
    input  logic nap,
    input  logic asleep,
    output logic bus_oe
);
    logic rd_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= (op == OP_READ);
        end
    end

    assign bus_oe = rd_valid && !drv_en_n && !wq && !nap && !asleep;

endmodule

// File: rtl/sbsram.sv
module sbsram
    import sbsram_pkg::*;
#(
    parameter int AW    = 10,
    parameter int LANES = 4,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs0_n,
    input  logic                cs1,
    input  logic                cs2_n,
    input  logic                proc_strb_n,
    input  logic                ctl_strb_n,
    input  logic                step_n,
    input  logic                wr_all_n,
    input  logic                lane_wr_n,
    input  logic [LANES-1:0]    lane_sel_n,
    input  logic                lin_order,
    input  logic [AW-1:0]       addr,
    input  logic [LANES*LW-1:0] bus_i,
    output logic [LANES*LW-1:0] bus_o,
    output logic                bus_oe,
    input  logic                drv_en_n,
    input  logic                nap,
    output logic                proto_err
);
    op_e              op;
    logic [AW-1:0]    acc_addr;
    logic             asleep;
    logic             wq;
    logic [LANES-1:0] lane_we;

    assign wq      = !wr_all_n || (!lane_wr_n && !(&lane_sel_n));
    assign lane_we = wr_all_n ? ~lane_sel_n : {LANES{1'b1}};

    sbsram_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst(rst), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
        .proc_strb_n(proc_strb_n), .ctl_strb_n(ctl_strb_n), .step_n(step_n),
        .wq(wq), .lin_order(lin_order), .addr(addr), .nap(nap),
        .op(op), .acc_addr(acc_addr), .asleep(asleep), .proto_err(proto_err)
    );

    sbsram_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_array (
        .clk(clk), .op(op), .acc_addr(acc_addr), .lane_we(lane_we),
        .wdata(bus_i), .rdata(bus_o)
    );

    sbsram_busctl u_busctl (
        .clk(clk), .rst(rst), .op(op), .drv_en_n(drv_en_n), .wq(wq),
        .nap(nap), .asleep(asleep), .bus_oe(bus_oe)
    );

endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             drv_en_n,
    input logic             wr_all_n,
    input logic             lane_wr_n,
    input logic [LANES-1:0] lane_sel_n,
    input logic             nap,
    input logic             asleep,
    input logic             bus_oe,
    input logic             proto_err
);
    a_r7_oe_pin_off: assert property (@(posedge clk) disable iff (rst)
        drv_en_n |-> !bus_oe);

    a_r8_write_masks_bus: assert property (@(posedge clk) disable iff (rst)
        (!wr_all_n || (!lane_wr_n && !(&lane_sel_n))) |-> !bus_oe);

    a_r9_nap_floats_bus: assert property (@(posedge clk) disable iff (rst)
        (nap || asleep) |-> !bus_oe);

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    a_r11_reset_quiet: assert property (@(posedge clk)
        rst |=> (!proto_err && !bus_oe));
endmodule

bind sbsram sbsram_chk #(.LANES(LANES)) u_chk (
    .clk(clk), .rst(rst), .drv_en_n(drv_en_n), .wr_all_n(wr_all_n),
    .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n), .nap(nap),
    .asleep(u_ctrl.asleep), .bus_oe(bus_oe), .proto_err(proto_err)
);

// File: tb/sbsram_tb.sv
module sbsram_tb;
    localparam int AW = 6, LANES = 4, LW = 9, DW = LANES * LW, DEPTH = 1 << AW;

    logic clk = 1'b0, rst = 1'b1;
    logic cs0_n, cs1, cs2_n, proc_strb_n, ctl_strb_n, step_n;
    logic wr_all_n, lane_wr_n, lin_order, drv_en_n, nap;
    logic [LANES-1:0] lane_sel_n;
    logic [AW-1:0]    addr;
    logic [DW-1:0]    bus_i, bus_o;
    logic             bus_oe, proto_err;

    always #5 clk = ~clk;

    sbsram #(.AW(AW), .LANES(LANES), .LW(LW)) u_dut (
        .clk(clk), .rst(rst), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
        .proc_strb_n(proc_strb_n), .ctl_strb_n(ctl_strb_n), .step_n(step_n),
        .wr_all_n(wr_all_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
        .lin_order(lin_order), .addr(addr), .bus_i(bus_i), .bus_o(bus_o),
        .bus_oe(bus_oe), .drv_en_n(drv_en_n), .nap(nap), .proto_err(proto_err)
    );

    // reference model state
    logic [DW-1:0] m_mem [DEPTH];
    logic [DW-1:0] m_rdata;
    int  m_base, m_first, m_cnt, m_rec;
    bit  m_open, m_rvld, m_err, m_s1, m_s2;
    int  checks = 0, fails = 0;
    bit  done = 0;

    function automatic bit wq_now();
        return !wr_all_n || (!lane_wr_n && lane_sel_n != '1);
    endfunction

    function automatic bit exp_oe();
        return m_rvld && !drv_en_n && !wq_now() && !nap && !m_s2;
    endfunction

    function automatic logic [DW-1:0] pat(input int a, input int k);
        return DW'((a * 32'h0102_0304 + k * 32'h0A0B_0C0D) ^ 32'h3C5A_96E1);
    endfunction

    task automatic model_edge();
        bit wq, sel;
        int op, a;
        wq  = wq_now();
        sel = !cs0_n && cs1 && !cs2_n;
        op  = 0;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_rec = 0; m_open = 0; m_rvld = 0; m_err = 0;
            m_base = 0; m_first = 0; m_cnt = 0;
            return;
        end
        if (m_s2) m_open = 0;
        else if (m_rec > 0) begin
            if (!proc_strb_n || !ctl_strb_n) m_err = 1;
        end else if ((!proc_strb_n && !cs0_n) || !ctl_strb_n) begin
            if (sel) begin
                m_open = 1; m_base = int'(addr) / 4; m_first = int'(addr) % 4; m_cnt = 0;
                op = (!proc_strb_n && !cs0_n) ? 1 : (wq ? 2 : 1);
            end else m_open = 0;
        end else if (m_open) begin
            if (!step_n) m_cnt = (m_cnt + 1) % 4;
            op = wq ? 2 : 1;
        end
        a = m_base * 4 + (lin_order ? (m_first + m_cnt) % 4 : (m_first ^ m_cnt));
        if (op == 2) begin
            for (int i = 0; i < LANES; i++)
                if (!wr_all_n || !lane_sel_n[i]) m_mem[a][i*LW +: LW] = bus_i[i*LW +: LW];
        end
        if (op == 1) m_rdata = m_mem[a];
        m_rvld = (op == 1);
        if (m_s2) m_rec = 2;
        else if (m_rec > 0) m_rec = m_rec - 1;
        m_s2 = m_s1;
        m_s1 = nap;
    endtask

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag);
        #1;
        chk(tag, DW'(bus_oe), DW'(exp_oe()), "bus_oe before edge");
        @(posedge clk);
        model_edge();
        #1;
        chk(tag, DW'(bus_oe), DW'(exp_oe()), "bus_oe after edge");
        chk(tag, DW'(proto_err), DW'(m_err), "proto_err");
        if (exp_oe()) chk(tag, bus_o, m_rdata, "bus_o");
        @(negedge clk);
    endtask

    task automatic idle();
        cs0_n = 0; cs1 = 1; cs2_n = 0; proc_strb_n = 1; ctl_strb_n = 1; step_n = 1;
        wr_all_n = 1; lane_wr_n = 1; lane_sel_n = '1; drv_en_n = 0; nap = 0;
    endtask

    task automatic end_burst();
        idle(); cs0_n = 1; ctl_strb_n = 0; step("R4"); idle();
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d, input string tag);
        idle(); addr = AW'(a); ctl_strb_n = 0; wr_all_n = 0; bus_i = d; step(tag); idle();
    endtask

    task automatic rd(input int a, input string tag);
        idle(); addr = AW'(a); ctl_strb_n = 0; step(tag); idle();
    endtask

    task automatic burst(input int a, input bit lin, input string tag);
        idle(); lin_order = lin; addr = AW'(a); ctl_strb_n = 0; step(tag);
        idle();
        for (int k = 0; k < 5; k++) begin step_n = 0; step(tag); end
        end_burst();
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(); lin_order = 1; addr = '0; bus_i = '0; rst = 1;
        @(negedge clk);
        step("R11"); step("R11");
        rst = 0;
        chk("R11", DW'(proto_err), '0, "proto_err after reset");
        step("R11");
        // preload every word
        for (int a = 0; a < DEPTH; a++) wr(a, pat(a, 0), "R2");
        end_burst();
        for (int a = 0; a < DEPTH; a += 7) rd(a, "R6");
        end_burst();
        // burst orders, all start offsets
        for (int s = 0; s < 4; s++) burst(16 + s, 1, "R5");
        for (int s = 0; s < 4; s++) burst(32 + s, 0, "R5");
        // byte-lane masks
        idle(); addr = 6'd9; ctl_strb_n = 0; lane_wr_n = 0; lane_sel_n = 4'b1010;
        bus_i = pat(9, 3); step("R1");
        idle(); lane_wr_n = 0; lane_sel_n = 4'b0111; bus_i = pat(9, 5); step("R1");
        end_burst(); rd(9, "R1"); end_burst();
        // lane selects without lane_wr_n: read, no write
        idle(); addr = 6'd10; ctl_strb_n = 0; lane_sel_n = 4'b0000; bus_i = '1; step("R2");
        idle(); step("R2"); end_burst(); rd(10, "R2"); end_burst();
        // processor strobe starts a read even with write enables low
        idle(); addr = 6'd20; proc_strb_n = 0; wr_all_n = 0; bus_i = pat(20, 9); step("R3");
        idle(); step_n = 0; wr_all_n = 0; bus_i = pat(21, 9); step("R3");
        idle(); step("R3"); end_burst(); rd(20, "R3"); rd(21, "R3"); end_burst();
        // processor strobe ignored when cs0_n high
        idle(); cs0_n = 1; proc_strb_n = 0; addr = 6'd5; step("R4"); idle(); step("R4");
        // output enable and write masking of an active read
        rd(40, "R6");
        drv_en_n = 1; step("R7"); drv_en_n = 0; step("R7");
        wr_all_n = 1; lane_wr_n = 0; lane_sel_n = 4'b1110; bus_i = pat(40, 2); step("R8");
        idle(); step("R8"); end_burst();
        // suspend repeats the address
        rd(44, "R12"); step("R12"); step("R12"); end_burst();
        // deselect variants
        rd(12, "R4"); cs2_n = 1; proc_strb_n = 0; step("R4"); idle(); step_n = 0; step("R4");
        rd(13, "R4"); cs1 = 0; ctl_strb_n = 0; step("R4"); idle(); step_n = 0; step("R4");
        // nap in mid-burst, strobes while asleep, recovery violation
        idle(); lin_order = 1; addr = 6'd48; ctl_strb_n = 0; step("R9");
        idle(); step_n = 0; nap = 1; step("R9"); step("R9"); step("R9");
        idle(); nap = 1; ctl_strb_n = 0; addr = 6'd50; wr_all_n = 0; bus_i = '0; step("R9");
        idle(); nap = 1; step("R9");
        idle(); step("R9"); step("R9");
        idle(); ctl_strb_n = 0; addr = 6'd51; step("R10");
        idle(); step("R10"); step("R10");
        rd(50, "R9"); rd(51, "R9"); end_burst();
        step("R10");
        rst = 1; step("R11"); rst = 0; idle(); step("R11");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule